// File: doc/BRIEF.md
# Precision-Grouping Operand Scheduler

The block sits in front of a reconfigurable multiplier array. It takes a stream of operand pairs, works out the smallest precision class each pair fits (8, 16 or 32 bits), and parks the pair in a queue for that class. It then releases the pairs one class at a time, so the supply and clock settings of the downstream array change only when the class being released changes. For the class in service it drives a supply-level code and a clock-rate select looked up from a fixed three-entry table. Each time that setting changes, it waits one cycle before releasing data at the new setting.

The controller is a three-state machine. PICK chooses the next class. Classes are tried in rotation, starting with the class after the one served last; before any class has been served, the order is 8, 16, 32. PICK takes the transition to SETTLE when the chosen class differs from the current one, or when no class has been served yet. It takes the transition straight to ISSUE when the same class is chosen again. PICK stays in PICK while all queues are empty. SETTLE always moves to ISSUE after one cycle. ISSUE releases pairs of the current class. It takes the transition back to PICK once that queue is empty, or once the batch has reached its cap. A counter of supply-code changes lets the effect of grouping be measured.

Top module: `pgs_sched`

## Requirements
- R1: For an unsigned pair, the need of each operand is the position of its highest set bit plus one, and zero needs 0 bits. The pair's class is taken from the larger need: 0–8 bits gives mode 0 (8-bit), 9–16 bits gives mode 1 (16-bit), and 17–32 bits gives mode 2 (32-bit). The class is reported on out_mode.
- R2: For a signed pair (in_signed=1), an operand's need is the unsigned need of the value, or of its bitwise inverse when the value is negative, plus one. For example, -128 and 127 both need 8 bits, while 128 and -129 both need 9 bits.
- R3: Each class has its own 8-entry queue. in_ready is low exactly when the queue for the offered pair's class is full, whatever the other queues hold. A pair offered while in_ready is low is dropped. Pairs of one class leave in the order they arrived.
- R4: The current class is drained until its queue is empty. The next class is then the first non-empty class in the rotation 8→16→32→8 that starts after the current class.
- R5: At most 16 pairs are released in one batch. After 16, another non-empty class is served before the current class resumes.
- R6: While a pair of class m is offered, volt_code and freq_sel both equal m+1. Codes 1, 2 and 3 stand for 1.3 V / 1.25 GHz, 1.7 V / 0.63 GHz and 2.2 V / 0.56 GHz.
- R7: After reset, volt_code=0 and freq_sel=0, which stand for the standard 3.3 V level and the nominal clock. out_valid=0, vswitch_count=0 and in_ready=1.
- R8: When the setting changes, out_valid stays low in the cycle after the change and the first pair is offered one cycle later. A new batch of the same class starts without that extra cycle.
- R9: vswitch_count increases by exactly one on every change of volt_code.
- R10: While out_valid is high and out_ready is low, out_valid, out_a, out_b, out_signed and out_mode hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Queue for the offered pair's class has room |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_signed | input | 1 | Operands are two's complement |
| out_valid | output | 1 | Pair offered to the multiplier |
| out_ready | input | 1 | Multiplier takes the pair |
| out_a | output | 32 | First operand out |
| out_b | output | 32 | Second operand out |
| out_signed | output | 1 | Signedness of the pair out |
| out_mode | output | 2 | Precision class: 0=8, 1=16, 2=32 bits |
| volt_code | output | 2 | Supply-level code, 0=standard |
| freq_sel | output | 2 | Clock-rate select, 0=nominal |
| vswitch_count | output | 16 | Number of supply-code changes |

## Verification
Two events can land in the same cycle. One is the batch cap in ISSUE. The other is input acceptance into the queue being drained, which keeps that queue from ever emptying. To provoke this, the bench fills the 8-bit queue, parks one 32-bit pair, and then pushes a new 8-bit pair on every cycle while popping on every cycle. It judges the result by requiring exactly 16 releases of mode 0 followed by the 32-bit pair. A separate collision is acceptance into the full queue of one class while the bench offers pairs of another class. The bench judges this on in_ready at the port.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
    localparam int NCLS = 3;

    typedef enum logic [1:0] {
        CLS_8  = 2'd0,
        CLS_16 = 2'd1,
        CLS_32 = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        ST_PICK   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ISSUE  = 2'd2
    } st_e;

    localparam logic [1:0] OP_NOMINAL = 2'd0;
    localparam logic [1:0] OP_LOW     = 2'd1;
    localparam logic [1:0] OP_MID     = 2'd2;
    localparam logic [1:0] OP_HIGH    = 2'd3;
endpackage

// File: rtl/pgs_range_det.sv
`timescale 1ns/1ps
module pgs_range_det #(
    parameter int W      = 32,
    parameter int NARROW = 8,
    parameter int MID    = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output pgs_pkg::cls_e  cls
);
    localparam int LW = $clog2(W + 2);

    function automatic logic [LW-1:0] need_bits(input logic [W-1:0] v, input logic s);
        logic [W-1:0]  mag;
        logic [LW-1:0] n;
        mag = (s && v[W-1]) ? ~v : v;
        n   = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) n = LW'(i + 1);
        end
        if (s) n = n + 1'b1;
        return n;
    endfunction

    logic [LW-1:0] need_a, need_b, need_max;

    always_comb begin
        need_a   = need_bits(a, sgn);
        need_b   = need_bits(b, sgn);
        need_max = (need_a > need_b) ? need_a : need_b;
        if (need_max <= LW'(NARROW))   cls = pgs_pkg::CLS_8;
        else if (need_max <= LW'(MID)) cls = pgs_pkg::CLS_16;
        else                           cls = pgs_pkg::CLS_32;
    end
endmodule

// File: rtl/pgs_fifo.sv
`timescale 1ns/1ps
module pgs_fifo #(
    parameter int DW    = 65,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = mem[rp];
    assign full  = (cnt == CAP);
    assign empty = (cnt == '0);

    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pgs_optable.sv
`timescale 1ns/1ps
module pgs_optable (
    input  pgs_pkg::cls_e cls,
    output logic [1:0]    vcode,
    output logic [1:0]    fsel
);
    always_comb begin
        unique case (cls)
            pgs_pkg::CLS_8:  begin vcode = pgs_pkg::OP_LOW;  fsel = pgs_pkg::OP_LOW;  end
            pgs_pkg::CLS_16: begin vcode = pgs_pkg::OP_MID;  fsel = pgs_pkg::OP_MID;  end
            pgs_pkg::CLS_32: begin vcode = pgs_pkg::OP_HIGH; fsel = pgs_pkg::OP_HIGH; end
            default:         begin vcode = pgs_pkg::OP_NOMINAL; fsel = pgs_pkg::OP_NOMINAL; end
        endcase
    end
endmodule

// File: rtl/pgs_sched.sv
`timescale 1ns/1ps
module pgs_sched #(
    parameter int W         = 32,
    parameter int DEPTH     = 8,
    parameter int BATCH_MAX = 16,
    parameter int CNTW      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    input  logic            in_signed,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [W-1:0]    out_a,
    output logic [W-1:0]    out_b,
    output logic            out_signed,
    output logic [1:0]      out_mode,
    output logic [1:0]      volt_code,
    output logic [1:0]      freq_sel,
    output logic [CNTW-1:0] vswitch_count
);
    import pgs_pkg::*;

    localparam int DW = 2 * W + 1;
    localparam int BW = $clog2(BATCH_MAX + 1);
    localparam logic [BW-1:0] BMAX = BW'(BATCH_MAX);

    cls_e              in_cls, cur, pick_cls;
    st_e               state, state_nx;
    logic              started, pick_ok, issue_ok;
    logic [BW-1:0]     batch;
    logic [NCLS-1:0]   push, pop, full, empty;
    logic [DW-1:0]     head [NCLS];
    logic [DW-1:0]     out_word;
    logic [1:0]        tab_v, tab_f;

    pgs_range_det #(.W(W)) u_rdet (
        .a(in_a), .b(in_b), .sgn(in_signed), .cls(in_cls)
    );

    assign in_ready = !full[in_cls];

    for (genvar g = 0; g < NCLS; g++) begin : g_q
        assign push[g] = in_valid && (in_cls == cls_e'(g)) && !full[g];
        assign pop[g]  = issue_ok && out_ready && (cur == cls_e'(g));
        pgs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push[g]), .wdata({in_signed, in_a, in_b}),
            .pop(pop[g]), .rdata(head[g]),
            .full(full[g]), .empty(empty[g])
        );
    end

    // Rotating choice of the next non-empty class.
    always_comb begin
        logic [1:0] idx;
        pick_ok  = 1'b0;
        pick_cls = CLS_8;
        for (int k = 0; k < NCLS; k++) begin
            idx = started ? 2'((int'(cur) + k + 1) % NCLS) : 2'(k);
            if (!pick_ok && !empty[idx]) begin
                pick_ok  = 1'b1;
                pick_cls = cls_e'(idx);
            end
        end
    end

    pgs_optable u_tab (.cls(pick_cls), .vcode(tab_v), .fsel(tab_f));

    assign issue_ok = (state == ST_ISSUE) && !empty[cur] && (batch < BMAX);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PICK:
                if (pick_ok)
                    state_nx = (started && pick_cls == cur) ? ST_ISSUE : ST_SETTLE;
            ST_SETTLE: state_nx = ST_ISSUE;
            ST_ISSUE:  if (!issue_ok) state_nx = ST_PICK;
            default:   state_nx = ST_PICK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PICK;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur           <= CLS_8;
            started       <= 1'b0;
            batch         <= '0;
            volt_code     <= OP_NOMINAL;
            freq_sel      <= OP_NOMINAL;
            vswitch_count <= '0;
        end else begin
            if (state == ST_PICK && pick_ok) begin
                batch   <= '0;
                started <= 1'b1;
                cur     <= pick_cls;
                if (!started || pick_cls != cur) begin
                    volt_code     <= tab_v;
                    freq_sel      <= tab_f;
                    vswitch_count <= vswitch_count + 1'b1;
                end
            end else if (issue_ok && out_ready) begin
                batch <= batch + 1'b1;
            end
        end
    end

    assign out_valid = issue_ok;
    assign out_word  = head[cur];
    assign out_signed = out_word[DW-1];
    assign out_a     = out_word[2*W-1:W];
    assign out_b     = out_word[W-1:0];
    assign out_mode  = cur;

    assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $stable(volt_code));
    assert_mode_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (volt_code == out_mode + 2'd1 && freq_sel == out_mode + 2'd1));
    assert_batch_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        batch <= BMAX);
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code != $past(volt_code)) |-> (vswitch_count == CNTW'($past(vswitch_count) + 1'b1)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)
                                       && $stable(out_mode) && $stable(out_signed)));
endmodule

// File: tb/sim_pgs_sched.sv
`timescale 1ns/1ps
module sim_pgs_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_signed = 1'b0, out_ready = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_ready, out_valid, out_signed;
    logic [31:0] out_a, out_b;
    logic [1:0]  out_mode, volt_code, freq_sel;
    logic [15:0] vswitch_count;

    int nchk = 0, nfail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    pgs_sched u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_signed(in_signed),
        .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b),
        .out_signed(out_signed), .out_mode(out_mode), .volt_code(volt_code),
        .freq_sel(freq_sel), .vswitch_count(vswitch_count)
    );

    // {a, b, signed, expected mode}
    localparam logic [66:0] VEC [16] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0, 2'd0},
        {32'h0000_00FF, 32'h0000_0000, 1'b0, 2'd0},
        {32'h0000_0000, 32'h0000_0100, 1'b0, 2'd1},
        {32'h0000_FFFF, 32'h0000_0012, 1'b0, 2'd1},
        {32'h0001_0000, 32'h0000_0001, 1'b0, 2'd2},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 2'd2},
        {32'h0000_0003, 32'h0000_1234, 1'b0, 2'd1},
        {32'hFFFF_FF80, 32'h0000_007F, 1'b1, 2'd0},
        {32'h0000_0080, 32'h0000_0000, 1'b1, 2'd1},
        {32'hFFFF_FF7F, 32'h0000_0001, 1'b1, 2'd1},
        {32'h0000_7FFF, 32'hFFFF_FFFF, 1'b1, 2'd1},
        {32'h0000_8000, 32'h0000_0000, 1'b1, 2'd2},
        {32'h8000_0000, 32'h0000_0005, 1'b1, 2'd2},
        {32'hFFFF_8000, 32'h0000_7FFF, 1'b1, 2'd1},
        {32'h0000_00FF, 32'h0000_00FF, 1'b1, 2'd1},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'd0}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_a = '0; in_b = '0; in_signed = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (out_valid) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    logic [31:0] got [20];
    logic [1:0]  gmode [20];

    initial begin
        bit ok;
        int np, k;
        logic [31:0] ea, eb;
        logic es;
        logic [1:0] em;

        // R7: reset state
        do_reset();
        chk(!out_valid && volt_code == 2'd0 && freq_sel == 2'd0 && vswitch_count == 0 && in_ready,
            "R7 reset state", {out_valid, volt_code, freq_sel, vswitch_count, in_ready}, 64'h1);

        // Vector walk: R1/R2 classification, R6 table
        for (int v = 0; v < 16; v++) begin
            ea = VEC[v][66:35]; eb = VEC[v][34:3]; es = VEC[v][2]; em = VEC[v][1:0];
            @(negedge clk);
            in_valid = 1'b1; in_a = ea; in_b = eb; in_signed = es;
            @(negedge clk);
            in_valid = 1'b0;
            wait_valid(ok);
            chk(ok && out_mode == em && out_a == ea && out_b == eb && out_signed == es,
                es ? "R2 signed class" : "R1 unsigned class", {30'd0, out_mode, out_a}, {30'd0, em, ea});
            chk(ok && volt_code == em + 2'd1 && freq_sel == em + 2'd1,
                "R6 table code", {volt_code, freq_sel}, {em + 2'd1, em + 2'd1});
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end

        // R8/R9: settle timing
        do_reset();
        in_valid = 1'b1; in_a = 32'd5; in_b = 32'd0; in_signed = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(volt_code == 2'd0 && !out_valid, "R8 before pick", {volt_code, out_valid}, 64'h0);
        @(negedge clk);
        chk(volt_code == 2'd1 && !out_valid, "R8 settle cycle", {volt_code, out_valid}, {2'd1, 1'b0});
        chk(vswitch_count == 16'd1, "R9 count after first switch", vswitch_count, 1);
        @(negedge clk);
        chk(out_valid && out_a == 32'd5, "R8 issue after settle", {out_valid, out_a}, {1'b1, 32'd5});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_a = 32'd6;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && out_a == 32'd6 && vswitch_count == 16'd1, "R8 same class no settle",
            {out_valid, out_a, vswitch_count}, {1'b1, 32'd6, 16'd1});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;

        // R4/R9/R10: grouping and hold
        do_reset();
        begin
            logic [31:0] seq [6] = '{32'h11, 32'h2_0000, 32'h12, 32'h300, 32'h2_0001, 32'h13};
            logic [31:0] exp_o [6] = '{32'h11, 32'h12, 32'h13, 32'h300, 32'h2_0000, 32'h2_0001};
            for (int i = 0; i < 6; i++) begin
                in_valid = 1'b1; in_a = seq[i]; in_b = '0; in_signed = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b0;
            @(negedge clk);
            chk(out_valid && out_a == 32'h11 && out_mode == 2'd0, "R10 stall hold 1", out_a, 32'h11);
            @(negedge clk);
            chk(out_valid && out_a == 32'h11 && out_mode == 2'd0, "R10 stall hold 2", out_a, 32'h11);
            out_ready = 1'b1;
            np = 0;
            for (int c = 0; c < 60 && np < 6; c++) begin
                if (out_valid) begin got[np] = out_a; np++; end
                @(negedge clk);
            end
            out_ready = 1'b0;
            chk(np == 6, "R4 group drain count", np, 6);
            for (int i = 0; i < 6; i++)
                chk(got[i] == exp_o[i], "R4 group order", got[i], exp_o[i]);
            chk(vswitch_count == 16'd3, "R9 three switches", vswitch_count, 3);
        end

        // R3: per-class full, order, drop
        do_reset();
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_a = 32'h100 + i; in_b = '0; in_signed = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0; in_a = 32'h1FF;
        #1;
        chk(!in_ready, "R3 full class not ready", in_ready, 0);
        in_a = 32'd5;
        #1;
        chk(in_ready, "R3 other class ready", in_ready, 1);
        in_valid = 1'b1; in_a = 32'h1FF;
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        np = 0;
        for (int c = 0; c < 40; c++) begin
            if (out_valid) begin
                if (np < 20) got[np] = out_a;
                np++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(np == 8, "R3 dropped pair absent", np, 8);
        for (int i = 0; i < 8; i++)
            chk(got[i] == 32'h100 + i, "R3 arrival order", got[i], 32'h100 + i);

        // R5: batch cap while the served queue keeps refilling
        do_reset();
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_a = i; in_b = '0; in_signed = 1'b0;
            @(negedge clk);
        end
        in_a = 32'h4_0000;
        @(negedge clk);
        np = 0; k = 0;
        for (int c = 0; c < 120 && np < 17; c++) begin
            in_valid = 1'b1; in_a = 32'h20 + k; out_ready = 1'b1;
            #1;
            if (in_ready) k++;
            if (out_valid) begin gmode[np] = out_mode; got[np] = out_a; np++; end
            if (np < 17) @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        chk(np == 17, "R5 pops seen", np, 17);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (gmode[i] != 2'd0) ok = 1'b0;
        chk(ok, "R5 first batch all 8-bit", ok, 1);
        chk(gmode[16] == 2'd2 && got[16] == 32'h4_0000, "R5 switch after cap",
            {gmode[16], got[16]}, {2'd2, 32'h4_0000});

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule